// File: doc/BRIEF.md
# Receive Descriptor DMA Sequencer

This block moves received frames from a frame FIFO into memory buffers described by a linked run of fixed-size descriptors. Software prepares each descriptor and hands it over by setting its ownership bit. The sequencer fetches a descriptor, stores frame words into its buffer, and hands the descriptor back by rewriting its first word with the ownership bit cleared. The rewritten word also carries the segment flags, the frame length and the MAC status. A frame longer than one buffer spills into the next descriptor if software owns it to the engine. Otherwise the frame is cut short, and the outcome depends on a flush option.

When the engine meets a descriptor it does not own, it raises a sticky buffer-unavailable flag and suspends. With flushing enabled it first drops the frame that is pending in the FIFO. It leaves suspension on a poll-demand strobe or when the FIFO starts presenting data again, then reads the same descriptor once more. A per-frame 64-bit timestamp can be stored in words 2 and 3 of the last descriptor of a frame.

Descriptors take 16 bytes and follow one another at increasing addresses. Word 0 is control and status, word 1 holds the buffer size in bytes, word 2 holds the buffer byte address, and word 3 is spare.

Top module: `rxd_dma`

## Requirements
- R1: After reset `mem_req`, `fifo_pop` and `buf_unavail` are 0. The engine issues no memory request until `cfg_rx_en` is 1 and a list base has been loaded with `cfg_base_load` while idle.
- R2: The engine reads word 0 (byte offset 0) of the current descriptor. Only when bit 31 (ownership) is 1 does it go on to read word 1 (offset 4, buffer size in bits [SZW-1:0]) and word 2 (offset 8, buffer byte address).
- R3: Each FIFO word is written to the buffer address plus 4·k, in arrival order. `fifo_pop` pulses once per acknowledged write and is never high while `fifo_valid` is low.
- R4: On the end-of-frame word the engine writes word 0 of the current descriptor with bit 31 = 0, bit 30 = 0, bit 29 (last segment) = 1, bits [28:16] = frame length in bytes, and bits [15:0] = `fifo_status`. The final word counts `fifo_eof_bytes` bytes, where 0 means 4. The next descriptor is 16 bytes further on.
- R5: If the buffer fills before the frame ends and the next descriptor's ownership bit is 1, word 0 of the current descriptor is written as 0x00000000. The frame then continues in the next descriptor's buffer.
- R6: If the buffer fills before the frame ends, the next descriptor is not owned and flushing is off, word 0 is written with bit 30 (descriptor error) = 1, bit 29 = 1 and the length stored so far. The engine then suspends with the rest of the frame left in the FIFO.
- R7: In the same case with flushing on, word 0 is written as 0x00000000. The rest of the frame is popped without any memory write, and the engine then suspends.
- R8: With `cfg_ts_en` = 1 and `fifo_ts_ok` = 1 on the end-of-frame word, `fifo_ts[31:0]` goes to word 2 and `fifo_ts[63:32]` to word 3 before word 0 is written. Otherwise words 2 and 3 are not written.
- R9: A fetched descriptor whose ownership bit is 0 sets `buf_unavail` and causes no buffer write. With flushing on, a frame already presented by the FIFO is discarded.
- R10: `buf_unavail` stays 1 until a cycle with `buf_unavail_clr` = 1.
- R11: While suspended, a `poll_demand` pulse or a low-to-high change of `fifo_valid` makes the engine read word 0 of the same descriptor again.
- R12: With `cfg_rx_en` = 0, a suspended engine, or one waiting between frames, goes idle. It then issues no memory request and pops nothing.
- R13: Once raised, `mem_req` stays high with `mem_addr`, `mem_we` and `mem_wdata` unchanged until the cycle `mem_ack` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rx_en | input | 1 | Receive enable |
| cfg_flush_en | input | 1 | Discard frames that find no buffer |
| cfg_ts_en | input | 1 | Store frame timestamps |
| cfg_base_load | input | 1 | Load `cfg_list_base` as the current descriptor (idle only) |
| cfg_list_base | input | AW | Byte address of the first descriptor |
| poll_demand | input | 1 | Software poll strobe |
| buf_unavail_clr | input | 1 | Clear the buffer-unavailable flag |
| buf_unavail | output | 1 | Sticky buffer-unavailable flag |
| fifo_valid | input | 1 | FIFO presents a word |
| fifo_data | input | 32 | Frame word |
| fifo_eof | input | 1 | Word is the last of its frame |
| fifo_eof_bytes | input | 2 | Valid bytes in the last word (0 = 4) |
| fifo_status | input | 16 | MAC receive status, valid with `fifo_eof` |
| fifo_ts | input | 64 | Captured timestamp, valid with `fifo_eof` |
| fifo_ts_ok | input | 1 | Frame qualifies for timestamp storage |
| fifo_pop | output | 1 | Consume the presented word |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Request accepted |

## Verification
The main function is exercised with five frame shapes. A two-word frame with a partial last word checks the length arithmetic. A three-word frame crossing an owned boundary with a timestamp checks chaining and the write order. A frame overrunning into an unowned descriptor is run once with flushing off and once with flushing on, which separates the error/last-segment encodings and whether the remainder is kept or dropped. A frame arriving with no owned descriptor and flushing on shows discard at a frame boundary. The leftover word from the no-flush overrun is later taken up by a FIFO-edge resume, which tells the two wake-up paths apart. A scoreboard matches every memory write against an ordered expectation list, so any stray or reordered write is caught.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

    localparam int WORD_W     = 32;
    localparam int DESC_BYTES = 16;
    localparam int LEN_W      = 13;
    localparam int STAT_W     = 16;
    localparam int OWN_BIT    = 31;

    typedef enum logic [3:0] {
        S_IDLE, S_FETCH0, S_FETCH1, S_FETCH2, S_DATA, S_PEEK,
        S_TSLO, S_TSHI, S_CLOSE, S_NOBUF, S_DROP, S_SUSP
    } rxd_state_e;

    typedef struct packed {
        logic              de;
        logic              ls;
        logic [LEN_W-1:0]  len;
        logic [STAT_W-1:0] stat;
    } close_info_t;

    function automatic logic [WORD_W-1:0] pack_w0(close_info_t c);
        return {1'b0, c.de, c.ls, c.len, c.stat};
    endfunction

    function automatic logic [2:0] last_bytes(logic [1:0] b);
        return (b == 2'd0) ? 3'd4 : {1'b0, b};
    endfunction

endpackage

// File: rtl/rxd_word0_fmt.sv
module rxd_word0_fmt
    import rxd_pkg::*;
(
    input  close_info_t       info,
    output logic [WORD_W-1:0] word0
);
    always_comb word0 = pack_w0(info);
endmodule

// File: rtl/rxd_sticky_flag.sv
module rxd_sticky_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)      flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
        flag && !clr |=> flag); // R10
endmodule

// File: rtl/rxd_mem_req.sv
module rxd_mem_req
    import rxd_pkg::*;
#(
    parameter int AW = 32
) (
    input  rxd_state_e        st,
    input  logic [AW-1:0]     cur_desc,
    input  logic [AW-1:0]     wr_ptr,
    input  logic              fifo_valid,
    input  logic [WORD_W-1:0] fifo_data,
    input  logic [63:0]       ts,
    input  logic [WORD_W-1:0] word0,
    output logic              req,
    output logic              we,
    output logic [AW-1:0]     addr,
    output logic [WORD_W-1:0] wdata
);
    localparam logic [AW-1:0] OFS_W1   = AW'(4);
    localparam logic [AW-1:0] OFS_W2   = AW'(8);
    localparam logic [AW-1:0] OFS_W3   = AW'(12);
    localparam logic [AW-1:0] OFS_NEXT = AW'(DESC_BYTES);

    always_comb begin
        req   = 1'b0;
        we    = 1'b0;
        addr  = cur_desc;
        wdata = '0;
        case (st)
            S_FETCH0: req = 1'b1;
            S_FETCH1: begin req = 1'b1; addr = cur_desc + OFS_W1; end
            S_FETCH2: begin req = 1'b1; addr = cur_desc + OFS_W2; end
            S_PEEK:   begin req = 1'b1; addr = cur_desc + OFS_NEXT; end
            S_DATA: begin
                req = fifo_valid; we = 1'b1; addr = wr_ptr; wdata = fifo_data;
            end
            S_TSLO: begin
                req = 1'b1; we = 1'b1; addr = cur_desc + OFS_W2; wdata = ts[31:0];
            end
            S_TSHI: begin
                req = 1'b1; we = 1'b1; addr = cur_desc + OFS_W3; wdata = ts[63:32];
            end
            S_CLOSE:  begin req = 1'b1; we = 1'b1; wdata = word0; end
            default: ;
        endcase
    end
endmodule

// File: rtl/rxd_seq.sv
module rxd_seq
    import rxd_pkg::*;
#(
    parameter int AW  = 32,
    parameter int SZW = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_rx_en,
    input  logic              cfg_flush_en,
    input  logic              cfg_ts_en,
    input  logic              cfg_base_load,
    input  logic [AW-1:0]     cfg_list_base,
    input  logic              poll_demand,
    input  logic              fifo_valid,
    input  logic              fifo_eof,
    input  logic [1:0]        fifo_eof_bytes,
    input  logic [STAT_W-1:0] fifo_status,
    input  logic [63:0]       fifo_ts,
    input  logic              fifo_ts_ok,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output rxd_state_e        st,
    output logic [AW-1:0]     cur_desc,
    output logic [AW-1:0]     wr_ptr,
    output logic [63:0]       ts,
    output close_info_t       cinfo,
    output logic              fifo_pop,
    output logic              nobuf_set
);
    localparam logic [AW-1:0] DSTEP = AW'(DESC_BYTES);

    rxd_state_e       st_q, after_q;
    logic [AW-1:0]    cur_q, buf_q;
    logic [SZW-1:0]   size_q, off_q, off_nx;
    logic [LEN_W-1:0] flen_q, flen_nx;
    logic             mid_q, base_ok_q, fv_q;
    logic [2:0]       bytes_now;

    always_comb begin
        bytes_now = fifo_eof ? last_bytes(fifo_eof_bytes) : 3'd4;
        off_nx    = off_q + SZW'(4);
        flen_nx   = flen_q + {{(LEN_W-3){1'b0}}, bytes_now};
        fifo_pop  = (st_q == S_DATA && mem_ack) || (st_q == S_DROP && fifo_valid);
        nobuf_set = (st_q == S_NOBUF);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= S_IDLE;
            after_q   <= S_FETCH0;
            cur_q     <= '0;
            buf_q     <= '0;
            size_q    <= '0;
            off_q     <= '0;
            flen_q    <= '0;
            mid_q     <= 1'b0;
            base_ok_q <= 1'b0;
            fv_q      <= 1'b0;
            ts        <= '0;
            cinfo     <= '0;
        end else begin
            fv_q <= fifo_valid;
            case (st_q)
                S_IDLE: begin
                    if (cfg_base_load) begin
                        cur_q     <= cfg_list_base;
                        base_ok_q <= 1'b1;
                    end
                    if (cfg_rx_en && base_ok_q) st_q <= S_FETCH0;
                end
                S_FETCH0: if (mem_ack) st_q <= mem_rdata[OWN_BIT] ? S_FETCH1 : S_NOBUF;
                S_FETCH1: if (mem_ack) begin
                    size_q <= mem_rdata[SZW-1:0];
                    st_q   <= S_FETCH2;
                end
                S_FETCH2: if (mem_ack) begin
                    buf_q <= mem_rdata[AW-1:0];
                    off_q <= '0;
                    st_q  <= S_DATA;
                end
                S_DATA: begin
                    if (mem_ack) begin
                        off_q <= off_nx;
                        if (fifo_eof) begin
                            mid_q       <= 1'b0;
                            flen_q      <= '0;
                            ts          <= fifo_ts;
                            cinfo.de    <= 1'b0;
                            cinfo.ls    <= 1'b1;
                            cinfo.len   <= flen_nx;
                            cinfo.stat  <= fifo_status;
                            after_q     <= S_FETCH0;
                            st_q        <= (cfg_ts_en && fifo_ts_ok) ? S_TSLO : S_CLOSE;
                        end else begin
                            mid_q  <= 1'b1;
                            flen_q <= flen_nx;
                            if (off_nx >= size_q) st_q <= S_PEEK;
                        end
                    end else if (!fifo_valid && !mid_q && !cfg_rx_en) begin
                        st_q <= S_IDLE;
                    end
                end
                S_PEEK: if (mem_ack) begin
                    st_q <= S_CLOSE;
                    if (mem_rdata[OWN_BIT]) begin
                        cinfo   <= '0;
                        after_q <= S_FETCH1;
                    end else begin
                        cinfo.de   <= !cfg_flush_en;
                        cinfo.ls   <= !cfg_flush_en;
                        cinfo.len  <= cfg_flush_en ? '0 : flen_q;
                        cinfo.stat <= '0;
                        flen_q     <= '0;
                        after_q    <= S_NOBUF;
                        if (!cfg_flush_en) mid_q <= 1'b0;
                    end
                end
                S_TSLO:  if (mem_ack) st_q <= S_TSHI;
                S_TSHI:  if (mem_ack) st_q <= S_CLOSE;
                S_CLOSE: if (mem_ack) begin
                    cur_q <= cur_q + DSTEP;
                    st_q  <= after_q;
                end
                S_NOBUF: st_q <= (cfg_flush_en && (mid_q || fifo_valid)) ? S_DROP : S_SUSP;
                S_DROP: if (fifo_valid && fifo_eof) begin
                    mid_q  <= 1'b0;
                    flen_q <= '0;
                    st_q   <= S_SUSP;
                end
                S_SUSP: begin
                    if (!cfg_rx_en) st_q <= S_IDLE;
                    else if (poll_demand || (fifo_valid && !fv_q)) st_q <= S_FETCH0;
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    assign st       = st_q;
    assign cur_desc = cur_q;
    assign wr_ptr   = buf_q + {{(AW-SZW){1'b0}}, off_q};

    AST_POP_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |-> fifo_valid); // R3
endmodule

// File: rtl/rxd_dma.sv
module rxd_dma
    import rxd_pkg::*;
#(
    parameter int AW  = 32,
    parameter int SZW = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_rx_en,
    input  logic              cfg_flush_en,
    input  logic              cfg_ts_en,
    input  logic              cfg_base_load,
    input  logic [AW-1:0]     cfg_list_base,
    input  logic              poll_demand,
    input  logic              buf_unavail_clr,
    output logic              buf_unavail,
    input  logic              fifo_valid,
    input  logic [31:0]       fifo_data,
    input  logic              fifo_eof,
    input  logic [1:0]        fifo_eof_bytes,
    input  logic [15:0]       fifo_status,
    input  logic [63:0]       fifo_ts,
    input  logic              fifo_ts_ok,
    output logic              fifo_pop,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ack
);
    rxd_state_e        st;
    logic [AW-1:0]     cur_desc, wr_ptr;
    logic [63:0]       ts;
    close_info_t       cinfo;
    logic [WORD_W-1:0] word0;
    logic              nobuf_set;

    rxd_seq #(.AW(AW), .SZW(SZW)) u_seq (
        .clk(clk), .rst(rst),
        .cfg_rx_en(cfg_rx_en), .cfg_flush_en(cfg_flush_en), .cfg_ts_en(cfg_ts_en),
        .cfg_base_load(cfg_base_load), .cfg_list_base(cfg_list_base),
        .poll_demand(poll_demand),
        .fifo_valid(fifo_valid), .fifo_eof(fifo_eof), .fifo_eof_bytes(fifo_eof_bytes),
        .fifo_status(fifo_status), .fifo_ts(fifo_ts), .fifo_ts_ok(fifo_ts_ok),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .st(st), .cur_desc(cur_desc), .wr_ptr(wr_ptr), .ts(ts), .cinfo(cinfo),
        .fifo_pop(fifo_pop), .nobuf_set(nobuf_set)
    );

    rxd_word0_fmt u_fmt (.info(cinfo), .word0(word0));

    rxd_mem_req #(.AW(AW)) u_req (
        .st(st), .cur_desc(cur_desc), .wr_ptr(wr_ptr), .fifo_valid(fifo_valid),
        .fifo_data(fifo_data), .ts(ts), .word0(word0),
        .req(mem_req), .we(mem_we), .addr(mem_addr), .wdata(mem_wdata)
    );

    rxd_sticky_flag u_flag (
        .clk(clk), .rst(rst), .set(nobuf_set), .clr(buf_unavail_clr), .flag(buf_unavail)
    );

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                                && $stable(mem_wdata)); // R13

    AST_FLAG_FROM_NOBUF: assert property (@(posedge clk) disable iff (rst)
        $rose(buf_unavail) |-> $past(st == S_NOBUF)); // R9

    AST_QUIET_WHEN_PARKED: assert property (@(posedge clk) disable iff (rst)
        (st == S_DROP || st == S_SUSP || st == S_IDLE || st == S_NOBUF) |-> !mem_req); // R7
endmodule

// File: tb/rxd_dma_bench.sv
`timescale 1ns/1ps
module rxd_dma_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_rx_en, cfg_flush_en, cfg_ts_en, cfg_base_load;
    logic [31:0] cfg_list_base;
    logic        poll_demand, buf_unavail_clr, buf_unavail;
    logic        fifo_valid, fifo_eof, fifo_ts_ok, fifo_pop;
    logic [31:0] fifo_data;
    logic [1:0]  fifo_eof_bytes;
    logic [15:0] fifo_status;
    logic [63:0] fifo_ts;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    always #10 clk = ~clk;

    rxd_dma u_rxd_dma (
        .clk(clk), .rst(rst), .cfg_rx_en(cfg_rx_en), .cfg_flush_en(cfg_flush_en),
        .cfg_ts_en(cfg_ts_en), .cfg_base_load(cfg_base_load), .cfg_list_base(cfg_list_base),
        .poll_demand(poll_demand), .buf_unavail_clr(buf_unavail_clr), .buf_unavail(buf_unavail),
        .fifo_valid(fifo_valid), .fifo_data(fifo_data), .fifo_eof(fifo_eof),
        .fifo_eof_bytes(fifo_eof_bytes), .fifo_status(fifo_status), .fifo_ts(fifo_ts),
        .fifo_ts_ok(fifo_ts_ok), .fifo_pop(fifo_pop), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    int checks = 0;
    int errors = 0;

    // memory model
    logic [31:0] mem [0:255];
    logic        pk_en = 1'b0;
    logic [7:0]  pk_a = '0;
    logic [31:0] pk_d = '0;
    assign mem_rdata = mem[mem_addr[9:2]];

    // FIFO model
    logic [31:0] fd  [0:255];
    logic        fe  [0:255];
    logic [1:0]  fb  [0:255];
    logic [15:0] fs  [0:255];
    logic        fk  [0:255];
    int          fhead, ftail = 0;
    logic        gate = 1'b1;
    logic [63:0] TS = 64'h1111_2222_3333_4444;
    assign fifo_valid     = gate && (fhead != ftail);
    assign fifo_data      = fd[fhead[7:0]];
    assign fifo_eof       = fe[fhead[7:0]];
    assign fifo_eof_bytes = fb[fhead[7:0]];
    assign fifo_status    = fs[fhead[7:0]];
    assign fifo_ts_ok     = fk[fhead[7:0]];
    assign fifo_ts        = TS;

    always @(posedge clk) begin
        if (rst) mem_ack <= 1'b0;
        else     mem_ack <= mem_req && !mem_ack;
        if (mem_req && mem_we && mem_ack) mem[mem_addr[9:2]] <= mem_wdata;
        if (pk_en) mem[pk_a] <= pk_d;
        if (rst) fhead <= 0;
        else if (fifo_pop) fhead <= fhead + 1;
    end

    // scoreboard
    logic [31:0] ea[$];
    logic [31:0] ed[$];
    string       et[$];
    logic        pend = 1'b0;
    logic [31:0] pend_a = '0;
    int          hs_err = 0;
    logic        quiet_win = 1'b0;
    int          quiet_req = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (mem_req && mem_we && mem_ack) begin
                if (ea.size() == 0) begin
                    chk(1'b0, "R7 R9", "unexpected write addr", {32'd0, mem_addr}, 64'd0);
                end else begin
                    logic [31:0] xa, xd;
                    string xt;
                    xa = ea.pop_front(); xd = ed.pop_front(); xt = et.pop_front();
                    chk(mem_addr == xa, xt, "write addr", {32'd0, mem_addr}, {32'd0, xa});
                    chk(mem_wdata == xd, xt, "write data", {32'd0, mem_wdata}, {32'd0, xd});
                end
            end
            if (pend && !(mem_req && mem_addr == pend_a)) hs_err++;
            pend   = mem_req && !mem_ack;
            pend_a = mem_addr;
            if (quiet_win && (mem_req || fifo_pop)) quiet_req++;
        end
    end

    task automatic expect_wr(input logic [31:0] a, input logic [31:0] d, input string t);
        ea.push_back(a); ed.push_back(d); et.push_back(t);
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk); pk_en = 1'b1; pk_a = a[9:2]; pk_d = d;
        @(negedge clk); pk_en = 1'b0;
    endtask

    task automatic set_desc(input int i, input bit own);
        poke(32'h100 + 16*i, own ? 32'h8000_0000 : 32'h0);
        poke(32'h104 + 16*i, 32'd8);
        poke(32'h108 + 16*i, 32'h200 + 32'h20*i);
    endtask

    task automatic push(input logic [31:0] d, input bit eof, input logic [1:0] b,
                        input logic [15:0] s, input bit tk);
        fd[ftail[7:0]] = d; fe[ftail[7:0]] = eof; fb[ftail[7:0]] = b;
        fs[ftail[7:0]] = s; fk[ftail[7:0]] = tk;
        ftail = ftail + 1;
    endtask

    task automatic pulse_poll();
        @(negedge clk); poll_demand = 1'b1; @(negedge clk); poll_demand = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk); buf_unavail_clr = 1'b1; @(negedge clk); buf_unavail_clr = 1'b0;
    endtask

    task automatic drain(input string t);
        for (int i = 0; i < 3000 && ea.size() != 0; i++) @(negedge clk);
        chk(ea.size() == 0, t, "expected writes outstanding", ea.size(), 0);
        repeat (20) @(negedge clk);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_rx_en = 0; cfg_flush_en = 0; cfg_ts_en = 0; cfg_base_load = 0;
        cfg_list_base = 32'h100; poll_demand = 0; buf_unavail_clr = 0;
        set_desc(0, 1); set_desc(1, 1); set_desc(2, 1); set_desc(3, 0);
        set_desc(4, 0); set_desc(5, 1); set_desc(6, 0); set_desc(7, 0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk(mem_req == 0, "R1", "mem_req after reset", mem_req, 0);
        chk(fifo_pop == 0, "R1", "fifo_pop after reset", fifo_pop, 0);
        chk(buf_unavail == 0, "R1", "buf_unavail after reset", buf_unavail, 0);
        cfg_rx_en = 1;
        quiet_win = 1'b1; repeat (10) @(negedge clk); quiet_win = 1'b0;
        chk(quiet_req == 0, "R1", "requests without base", quiet_req, 0);
        cfg_base_load = 1; @(negedge clk); cfg_base_load = 0;

        // R2 R3 R4: short frame, partial last word, no timestamp (R8 negative)
        expect_wr(32'h200, 32'hA000_0001, "R2");
        expect_wr(32'h204, 32'hA000_0002, "R3");
        expect_wr(32'h100, 32'h2007_1234, "R4 R8");
        push(32'hA000_0001, 0, 0, 0, 0);
        push(32'hA000_0002, 1, 3, 16'h1234, 1);
        drain("R4");

        // R5 R8: chain into owned descriptor, timestamp stored
        cfg_ts_en = 1;
        expect_wr(32'h220, 32'hB000_0001, "R5");
        expect_wr(32'h224, 32'hB000_0002, "R5");
        expect_wr(32'h110, 32'h0000_0000, "R5");
        expect_wr(32'h240, 32'hB000_0003, "R5");
        expect_wr(32'h128, 32'h3333_4444, "R8");
        expect_wr(32'h12C, 32'h1111_2222, "R8");
        expect_wr(32'h120, 32'h200C_0055, "R8 R4");
        push(32'hB000_0001, 0, 0, 0, 0);
        push(32'hB000_0002, 0, 0, 0, 0);
        push(32'hB000_0003, 1, 0, 16'h0055, 1);
        drain("R5");
        chk(buf_unavail == 1, "R9", "flag on unowned descriptor", buf_unavail, 1);
        repeat (10) @(negedge clk);
        chk(buf_unavail == 1, "R10", "flag still set", buf_unavail, 1);
        clear_flag();
        chk(buf_unavail == 0, "R10", "flag after clear", buf_unavail, 0);

        // R11 poll resume, R6 overrun with flushing off
        cfg_ts_en = 0;
        poke(32'h130, 32'h8000_0000);
        pulse_poll();
        expect_wr(32'h260, 32'hC000_0001, "R11");
        expect_wr(32'h264, 32'hC000_0002, "R6");
        expect_wr(32'h130, 32'h6008_0000, "R6");
        push(32'hC000_0001, 0, 0, 0, 0);
        push(32'hC000_0002, 0, 0, 0, 0);
        push(32'hC000_0003, 1, 2, 16'h0077, 0);
        drain("R6");
        chk(buf_unavail == 1, "R6", "flag after overrun", buf_unavail, 1);
        chk(ftail - fhead == 1, "R6", "words left in fifo", ftail - fhead, 1);
        clear_flag();

        // R11 resume on FIFO edge: leftover word becomes a frame
        poke(32'h140, 32'h8000_0000);
        gate = 1'b0; repeat (3) @(negedge clk); gate = 1'b1;
        expect_wr(32'h280, 32'hC000_0003, "R11");
        expect_wr(32'h140, 32'h2002_0077, "R11");
        drain("R11");

        // R7 overrun with flushing on
        cfg_flush_en = 1;
        expect_wr(32'h2A0, 32'hE000_0001, "R7");
        expect_wr(32'h2A4, 32'hE000_0002, "R7");
        expect_wr(32'h150, 32'h0000_0000, "R7");
        push(32'hE000_0001, 0, 0, 0, 0);
        push(32'hE000_0002, 0, 0, 0, 0);
        push(32'hE000_0003, 0, 0, 0, 0);
        push(32'hE000_0004, 1, 1, 16'h0099, 0);
        drain("R7");
        chk(ftail == fhead, "R7", "remainder dropped", ftail - fhead, 0);
        chk(buf_unavail == 1, "R7", "flag after flushed overrun", buf_unavail, 1);
        clear_flag();

        // R9 frame arriving with no owned descriptor, flushing on
        push(32'hF000_0001, 0, 0, 0, 0);
        push(32'hF000_0002, 1, 0, 16'h0011, 0);
        repeat (40) @(negedge clk);
        chk(ftail == fhead, "R9", "frame discarded", ftail - fhead, 0);
        chk(buf_unavail == 1, "R9", "flag set again", buf_unavail, 1);

        // R12 receive disabled
        cfg_rx_en = 0;
        repeat (5) @(negedge clk);
        quiet_req = 0; quiet_win = 1'b1;
        pulse_poll();
        push(32'hD000_0001, 1, 0, 0, 0);
        repeat (20) @(negedge clk);
        quiet_win = 1'b0;
        chk(quiet_req == 0, "R12", "activity while disabled", quiet_req, 0);
        chk(ftail - fhead == 1, "R12", "word not popped", ftail - fhead, 1);

        chk(hs_err == 0, "R13", "request changed before ack", hs_err, 0);
        chk(ea.size() == 0, "R3", "writes left unseen", ea.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule